// File: doc/BRIEF.md
# Program Bank Window and Mirroring Controller

This block sits on the CPU side of a cartridge bus and turns CPU register writes in the upper half of the address space into program-ROM bank numbers for four consecutive 8 KB CPU windows, plus a two-bit nametable mirroring code for the video side. Two bank registers can be switched by software. The last two windows' worth of ROM are tied to fixed banks at the top of the ROM. A swap control moves the first switchable bank between the lowest window and the third window, and the second-to-last bank takes the window that the first bank leaves.

Before it compares the address, the block ANDs it with a fixed mask, so many CPU addresses reach the same register. Each bank number is ANDed with the ROM size minus one, and the ROM size is given as a bank count on an input pin. ROM storage, character banking and interrupt logic live outside the block.

Top module: `prg_window_ctrl`

## Requirements
- R1: While `rst` is high, and until the first write after it, the window outputs are bank 0, bank 1, bank N-2 and bank N-1 for windows 0 to 3, where N is `bank_total`, and `mirror_mode` is 0.
- R2: The block ANDs the address with 0xF0CF before it selects a register. Aliased addresses such as 0x8F30 act like 0x8000. A write whose masked address matches no register changes no output.
- R3: A write whose masked address is 0x8000 loads the first switchable bank register with the data byte. While swap bit 1 is clear, window 0 (CPU $8000) shows that register.
- R4: While bit 1 of the swap register is set, window 0 shows bank N-2 and window 2 (CPU $C000) shows the first switchable register. While bit 1 is clear, window 2 shows bank N-2.
- R5: The swap register is written at masked address 0x9002 or 0x9080 and stores the whole data byte. Only bit 1 affects the outputs.
- R6: A write whose masked address is 0xA000 loads the register that window 1 (CPU $A000) shows.
- R7: A write whose masked address is 0x9000 sets `mirror_mode` to data bits [1:0]: 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper.
- R8: Window 3 (CPU $E000) always shows bank N-1, and no register write changes it.
- R9: Every window output is ANDed with N-1, so a register value larger than the ROM wraps onto an existing bank. N is a power of two from 2 to 256.
- R10: A register write shows at the outputs right after the rising clock edge at which `wr_en` is sampled high. Cycles with `wr_en` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| bank_total | input | 9 | Number of 8 KB program banks (power of two) |
| bank_w0 | output | 8 | Bank number for CPU $8000-$9FFF |
| bank_w1 | output | 8 | Bank number for CPU $A000-$BFFF |
| bank_w2 | output | 8 | Bank number for CPU $C000-$DFFF |
| bank_w3 | output | 8 | Bank number for CPU $E000-$FFFF |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The case that is hardest to reach from the ports is the interaction of the swap bit with an earlier bank write. The register value must move from window 0 to window 2 and back again without a new bank write. The stimulus therefore loads the first bank with swap clear and then turns swap on. With swap on it writes the bank again, and finally clears swap through the other alias using a byte that has only bit 0 set. The bench also changes `bank_total` while registers hold out-of-range values, so that the wrap and the moving fixed banks are seen in the same sequence.

// File: rtl/prg_window_pkg.sv
package prg_window_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] DEC_MASK = 16'hF0CF;

    localparam logic [ADDR_W-1:0] A_FIRST  = 16'h8000;
    localparam logic [ADDR_W-1:0] A_SECOND = 16'hA000;
    localparam logic [ADDR_W-1:0] A_MIRROR = 16'h9000;
    localparam logic [ADDR_W-1:0] A_SWAP_A = 16'h9002;
    localparam logic [ADDR_W-1:0] A_SWAP_B = 16'h9080;

    localparam int SWAP_BIT = 1;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_FIRST,
        TGT_SECOND,
        TGT_SWAP,
        TGT_MIRROR
    } wr_target_e;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    typedef struct packed {
        logic              valid;
        wr_target_e        tgt;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] first;
        logic [DATA_W-1:0] second;
        logic [DATA_W-1:0] swap;
        mirror_e           mirror;
    } prg_state_t;

    function automatic wr_target_e decode_target(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = a & DEC_MASK;
        case (m)
            A_FIRST:            return TGT_FIRST;
            A_SECOND:           return TGT_SECOND;
            A_MIRROR:           return TGT_MIRROR;
            A_SWAP_A, A_SWAP_B: return TGT_SWAP;
            default:            return TGT_NONE;
        endcase
    endfunction

    function automatic logic swap_on(input logic [DATA_W-1:0] s);
        return s[SWAP_BIT];
    endfunction

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
    import prg_window_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_req_t           req
);
    wr_target_e tgt;

    always_comb begin
        tgt       = decode_target(wr_addr);
        req.valid = wr_en && (tgt != TGT_NONE);
        req.tgt   = tgt;
        req.data  = wr_data;
    end
endmodule

// File: rtl/prg_reg_bank.sv
module prg_reg_bank
    import prg_window_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    req,
    output prg_state_t st
);
    prg_state_t st_q;
    prg_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (req.valid) begin
            unique case (req.tgt)
                TGT_FIRST:  st_d.first  = req.data;
                TGT_SECOND: st_d.second = req.data;
                TGT_SWAP:   st_d.swap   = req.data;
                TGT_MIRROR: st_d.mirror = mirror_e'(req.data[1:0]);
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.first  <= DATA_W'(0);
            st_q.second <= DATA_W'(1);
            st_q.swap   <= '0;
            st_q.mirror <= MIR_VERT;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_window_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int N_WIN  = 4
) (
    input  prg_state_t                     st,
    input  logic [BANK_W:0]                bank_total,
    output logic [N_WIN-1:0][BANK_W-1:0]   win_bank
);
    localparam int EXT_W = (BANK_W > DATA_W) ? BANK_W : DATA_W;

    logic [BANK_W-1:0] mask;
    logic [BANK_W-1:0] fixed_last;
    logic [BANK_W-1:0] fixed_prev;
    logic [BANK_W-1:0] first_b;
    logic [BANK_W-1:0] second_b;
    logic              swapped;

    always_comb begin
        mask       = BANK_W'(bank_total - 1'b1);
        fixed_last = BANK_W'(bank_total - 1'b1);
        fixed_prev = BANK_W'(bank_total - 2'd2);
        first_b    = BANK_W'(EXT_W'(st.first));
        second_b   = BANK_W'(EXT_W'(st.second));
        swapped    = swap_on(st.swap);
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        logic [BANK_W-1:0] raw;
        always_comb begin
            case (g)
                0:       raw = swapped ? fixed_prev : first_b;
                1:       raw = second_b;
                2:       raw = swapped ? first_b : fixed_prev;
                default: raw = fixed_last;
            endcase
            win_bank[g] = raw & mask;
        end
    end
endmodule

// File: rtl/prg_window_ctrl.sv
module prg_window_ctrl
    import prg_window_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [BANK_W:0]   bank_total,
    output logic [BANK_W-1:0] bank_w0,
    output logic [BANK_W-1:0] bank_w1,
    output logic [BANK_W-1:0] bank_w2,
    output logic [BANK_W-1:0] bank_w3,
    output logic [1:0]        mirror_mode
);
    localparam int N_WIN = 4;

    wr_req_t                     req;
    prg_state_t                  st;
    logic [N_WIN-1:0][BANK_W-1:0] win;

    prg_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    prg_reg_bank u_regs (
        .clk (clk),
        .rst (rst),
        .req (req),
        .st  (st)
    );

    prg_window_map #(.BANK_W(BANK_W), .N_WIN(N_WIN)) u_map (
        .st         (st),
        .bank_total (bank_total),
        .win_bank   (win)
    );

    assign bank_w0     = win[0];
    assign bank_w1     = win[1];
    assign bank_w2     = win[2];
    assign bank_w3     = win[3];
    assign mirror_mode = st.mirror;
endmodule

// File: rtl/prg_window_chk.sv
module prg_window_chk #(
    parameter int BANK_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [15:0]       wr_addr,
    input logic [7:0]        wr_data,
    input logic [BANK_W:0]   bank_total,
    input logic [BANK_W-1:0] bank_w0,
    input logic [BANK_W-1:0] bank_w1,
    input logic [BANK_W-1:0] bank_w2,
    input logic [BANK_W-1:0] bank_w3,
    input logic [1:0]        mirror_mode
);
    logic [BANK_W-1:0] n_last;
    logic [BANK_W-1:0] n_prev;
    logic [15:0]       m_addr;
    logic              hit_second;
    logic              hit_mirror;

    assign n_last     = BANK_W'(bank_total - 1'b1);
    assign n_prev     = BANK_W'(bank_total - 2'd2);
    assign m_addr     = wr_addr & 16'hF0CF;
    assign hit_second = wr_en && (m_addr == 16'hA000);
    assign hit_mirror = wr_en && (m_addr == 16'h9000);

    AST_LAST_FIXED: assert property (@(posedge clk) disable iff (rst)
        bank_w3 == n_last); // R8

    AST_PREV_PLACED: assert property (@(posedge clk) disable iff (rst)
        (bank_w0 == n_prev) || (bank_w2 == n_prev)); // R4

    AST_SECOND_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(hit_second) && $stable(bank_total)
        |-> bank_w1 == (BANK_W'($past(wr_data)) & n_last)); // R6

    AST_SECOND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(hit_second) && $stable(bank_total)
        |-> $stable(bank_w1)); // R10

    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(hit_mirror)
        |-> mirror_mode == $past(wr_data[1:0])); // R7

    AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(hit_mirror) |-> $stable(mirror_mode)); // R2
endmodule

bind prg_window_ctrl prg_window_chk #(.BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .bank_total  (bank_total),
    .bank_w0     (bank_w0),
    .bank_w1     (bank_w1),
    .bank_w2     (bank_w2),
    .bank_w3     (bank_w3),
    .mirror_mode (mirror_mode)
);

// File: tb/sim_prg_window_ctrl.sv
module sim_prg_window_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [8:0]  bank_total = 9'd16;
    logic [7:0]  bank_w0, bank_w1, bank_w2, bank_w3;
    logic [1:0]  mirror_mode;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_first, m_second, m_swap, m_mirror;

    always #5 clk = ~clk;

    prg_window_ctrl u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .bank_total (bank_total),
        .bank_w0 (bank_w0), .bank_w1 (bank_w1), .bank_w2 (bank_w2),
        .bank_w3 (bank_w3), .mirror_mode (mirror_mode)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        int n, mk, e0, e2;
        n  = bank_total;
        mk = n - 1;
        e0 = m_swap[1] ? (n - 2) : m_first;
        e2 = m_swap[1] ? m_first : (n - 2);
        check(tag, "win0", bank_w0, e0 & mk);
        check(tag, "win1", bank_w1, m_second & mk);
        check(tag, "win2", bank_w2, e2 & mk);
        check(tag, "win3", bank_w3, (n - 1) & mk);
        check(tag, "mirror", mirror_mode, m_mirror);
    endtask

    // one clock: drive, let edge happen, update model, compare
    task automatic step(input bit r, input bit en, input logic [15:0] a,
                        input logic [7:0] d, input string tag);
        rst = r; wr_en = en; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (r) begin
            m_first = 0; m_second = 1; m_swap = 0; m_mirror = 0;
        end else if (en) begin
            case (a & 16'hF0CF)
                16'h8000: m_first = d;
                16'hA000: m_second = d;
                16'h9000: m_mirror = d & 3;
                16'h9002, 16'h9080: m_swap = d;
                default: ;
            endcase
        end
        #2;
        compare_all(tag);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 0, 16'h0000, 8'h00, "R1");
        step(1, 1, 16'h8000, 8'h09, "R1");
        step(0, 0, 16'h0000, 8'h00, "R1");
        step(0, 0, 16'h8000, 8'h0B, "R10");
        step(0, 1, 16'h8000, 8'h05, "R3");
        step(0, 1, 16'hA000, 8'h07, "R6");
        step(0, 1, 16'h8F30, 8'h03, "R2");
        step(0, 1, 16'hA0C0, 8'h0C, "R2");
        step(0, 1, 16'hB000, 8'h0C, "R2");
        step(0, 1, 16'h7000, 8'h0C, "R2");
        step(0, 1, 16'h9000, 8'h01, "R7");
        step(0, 1, 16'h9000, 8'hFE, "R7");
        step(0, 1, 16'h9F30, 8'h03, "R7");
        step(0, 1, 16'h9000, 8'h04, "R7");
        step(0, 1, 16'h9002, 8'h02, "R4");
        step(0, 1, 16'h8000, 8'h06, "R4");
        step(0, 1, 16'hA000, 8'h02, "R6");
        step(0, 1, 16'h9080, 8'h01, "R5");
        step(0, 1, 16'h9080, 8'hFF, "R5");
        step(0, 1, 16'h9F82, 8'h00, "R5");
        step(0, 0, 16'h9002, 8'h02, "R10");
        bank_total = 9'd8;
        step(0, 1, 16'h8000, 8'h1D, "R9");
        step(0, 1, 16'hA000, 8'hFE, "R9");
        step(0, 1, 16'h9002, 8'h02, "R9");
        bank_total = 9'd32;
        step(0, 0, 16'h0000, 8'h00, "R8");
        step(0, 1, 16'hE000, 8'h00, "R8");
        bank_total = 9'd4;
        step(0, 1, 16'h8000, 8'hFF, "R9");
        bank_total = 9'd256;
        step(0, 1, 16'h8000, 8'hC4, "R8");
        step(1, 0, 16'h0000, 8'h00, "R1");
        step(0, 0, 16'h0000, 8'h00, "R1");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule